// File: doc/BRIEF.md
# Serial EEPROM Identification Loader

This block fetches two identification words from a small serial EEPROM as soon as a hardware reset is released. It talks to the device over four wires: a select, a serial clock, a line carrying command bits to the device, and a line carrying data back from it. The first word fetched becomes the vendor identifier and the second becomes the device identifier. Both are held on outputs that the bus configuration space presents to the host.

A board may leave the EEPROM unfitted. In that case the data line floats high and the first word arrives as all ones. The block then falls back to built-in default identifiers and skips the second read.

A done flag rises once the identifiers are final. The configuration logic must hold off configuration reads until the flag is high. The flag stays high until the next reset.

Top module: `eeprom_id_loader`

## Requirements
- R1: While reset is asserted, `load_done`, `ee_cs` and `ee_sk` are low and the ID outputs hold the default values. After reset is released, a read starts without any other input: `ee_cs` rises within three serial clock half-periods plus a few cycles.
- R2: Each read sends nine bits on `ee_di`, MSB first, one per rising edge of `ee_sk`. The bits are a start bit 1, the opcode bits 1 then 0, and then the 6-bit word address. The vendor word is read from address BASE_ADDR (default 0) and the device word from BASE_ADDR+1.
- R3: After the address, the device returns 16 data bits, MSB first. The loader samples `ee_do` on rising edges 10 to 25 of the selection, so any bit pattern is assembled exactly.
- R4: One `ee_sk` period lasts 2*HALF_DIV system clocks (1 µs at 200 MHz with the default). `ee_sk` is low whenever `ee_cs` is low, and `ee_di` changes only while `ee_sk` is low.
- R5: Before every selection, `ee_cs` stays low for at least one full `ee_sk` period (2*HALF_DIV system clocks).
- R6: When `load_done` is high, `id_vendor` equals the word at address 0 and `id_device` equals the word at address 1.
- R7: If the first word reads as 0xFFFF (device absent or erased), `id_vendor`/`id_device` take VENDOR_DEF/DEVICE_DEF (0x1D7A/0x0301 by default). No second read is made, and `load_done` rises after that single read.
- R8: A device word of 0xFFFF that follows a valid vendor word is kept as read.
- R9: Once `load_done` rises, it stays high, the ID outputs stay stable and `ee_cs` stays low until the next reset.
- R10: A reset asserted in the middle of a load abandons it. The next load restarts from the word at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ee_cs | output | 1 | EEPROM select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Command and address bits to the EEPROM |
| ee_do | input | 1 | Data bits from the EEPROM (reads high when absent) |
| id_vendor | output | 16 | Loaded or default vendor identifier |
| id_device | output | 16 | Loaded or default device identifier |
| load_done | output | 1 | Identifiers are final; configuration reads may proceed |

## Verification
Some rules are checked by assertions on every cycle:
- the serial clock is held low outside a selection;
- the serial clock moves only on a divider tick;
- the data-to-device line is steady while the serial clock is high;
- each selection is preceded by at least two low half-periods;
- once done is set, the done flag, the identifiers and the idle select are frozen.

Other behaviour only the bench scenarios can show, using a model of the EEPROM:
- the start/opcode/address content of each command;
- the MSB-first assembly of data words;
- the absent-device fallback with its single read;
- acceptance of an all-ones device word;
- the restart from word 0 after a reset in mid-load.

// File: rtl/eid_pkg.sv
package eid_pkg;
    typedef enum logic [1:0] {SH_IDLE, SH_GAP, SH_SEND, SH_RECV} sh_state_e;
    typedef enum logic [1:0] {LD_LAUNCH, LD_WAIT, LD_DONE} ld_state_e;
    // start bit followed by the two read opcode bits, sent before the address
    localparam logic [2:0] RD_PREFIX = 3'b110;
    // select-low interval before each read, in serial clock half-periods
    localparam int GAP_TICKS = 2;
endpackage

// File: rtl/eid_tick_gen.sv
module eid_tick_gen #(
    parameter int HALF_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tk_t;

    tk_t q, d;

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (q.cnt == CW'(HALF_DIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R4: half-period ticks are single-cycle pulses
    p_tick_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.tick |=> !q.tick);
endmodule

// File: rtl/eid_shifter.sv
module eid_shifter
    import eid_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic              word_done,
    output logic [DATA_W-1:0] word
);
    localparam int CMD_W = 3 + ADDR_W;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    typedef struct packed {
        sh_state_e         st;
        logic              cs;
        logic              sk;
        logic              di;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
        logic              done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        case (q.st)
            SH_IDLE: begin
                d.cs = 1'b0;
                d.sk = 1'b0;
                if (start) begin
                    d.st  = SH_GAP;
                    d.cnt = '0;
                    d.cmd = {RD_PREFIX, addr};
                end
            end
            SH_GAP: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(GAP_TICKS - 1)) begin
                        d.st  = SH_SEND;
                        d.cs  = 1'b1;
                        d.sk  = 1'b0;
                        d.di  = q.cmd[CMD_W-1];
                        d.cmd = q.cmd << 1;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SH_SEND: begin
                if (tick) begin
                    if (!q.sk) begin
                        d.sk = 1'b1;
                    end else begin
                        d.sk = 1'b0;
                        if (q.cnt == CNT_W'(CMD_W - 1)) begin
                            d.st  = SH_RECV;
                            d.cnt = '0;
                            d.di  = 1'b0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                            d.di  = q.cmd[CMD_W-1];
                            d.cmd = q.cmd << 1;
                        end
                    end
                end
            end
            SH_RECV: begin
                if (tick) begin
                    if (!q.sk) begin
                        d.sk   = 1'b1;
                        d.data = {q.data[DATA_W-2:0], ee_do};
                    end else begin
                        d.sk = 1'b0;
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.st   = SH_IDLE;
                            d.cs   = 1'b0;
                            d.done = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ee_cs     = q.cs;
    assign ee_sk     = q.sk;
    assign ee_di     = q.di;
    assign word_done = q.done;
    assign word      = q.data;

    // checker state: half-periods seen with select low, saturating
    logic [1:0] low_ticks_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          low_ticks_q <= '0;
        else if (q.cs)                       low_ticks_q <= '0;
        else if (tick && low_ticks_q != 2'd3) low_ticks_q <= low_ticks_q + 1'b1;
    end

    // R4: the serial clock never runs outside a selection
    p_sk_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);
    // R4: data to the device is steady across a high clock phase
    p_di_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ee_sk) && ee_sk) |-> $stable(ee_di));
    // R4: the serial clock only moves on a divider tick
    p_sk_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk != $past(ee_sk)) |-> $past(tick));
    // R5: one full serial period of idle select before each read
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (low_ticks_q >= 2'd2));
endmodule

// File: rtl/eeprom_id_loader.sv
module eeprom_id_loader
    import eid_pkg::*;
#(
    parameter int HALF_DIV   = 100,
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int BASE_ADDR  = 0,
    parameter int VENDOR_DEF = 16'h1D7A,
    parameter int DEVICE_DEF = 16'h0301
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    output logic [DATA_W-1:0] id_vendor,
    output logic [DATA_W-1:0] id_device,
    output logic              load_done
);
    typedef struct packed {
        ld_state_e         st;
        logic              idx;
        logic [DATA_W-1:0] vendor;
        logic [DATA_W-1:0] device;
        logic              done;
        logic              start;
    } ld_t;

    ld_t q, d;

    logic              tick;
    logic              word_done;
    logic [DATA_W-1:0] word;
    logic [ADDR_W-1:0] rd_addr;

    assign rd_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(q.idx);

    eid_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    eid_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (q.start),
        .addr     (rd_addr),
        .ee_do    (ee_do),
        .ee_cs    (ee_cs),
        .ee_sk    (ee_sk),
        .ee_di    (ee_di),
        .word_done(word_done),
        .word     (word)
    );

    always_comb begin
        d = q;
        d.start = 1'b0;
        case (q.st)
            LD_LAUNCH: begin
                d.start = 1'b1;
                d.st    = LD_WAIT;
            end
            LD_WAIT: begin
                if (word_done) begin
                    if (!q.idx) begin
                        if (&word) begin
                            d.vendor = DATA_W'(VENDOR_DEF);
                            d.device = DATA_W'(DEVICE_DEF);
                            d.done   = 1'b1;
                            d.st     = LD_DONE;
                        end else begin
                            d.vendor = word;
                            d.idx    = 1'b1;
                            d.st     = LD_LAUNCH;
                        end
                    end else begin
                        d.device = word;
                        d.done   = 1'b1;
                        d.st     = LD_DONE;
                    end
                end
            end
            LD_DONE: d.st = LD_DONE;
            default: d.st = LD_LAUNCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= LD_LAUNCH;
            q.vendor <= DATA_W'(VENDOR_DEF);
            q.device <= DATA_W'(DEVICE_DEF);
        end else begin
            q <= d;
        end
    end

    assign id_vendor = q.vendor;
    assign id_device = q.device;
    assign load_done = q.done;

    // R9: done is sticky until reset
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);
    // R9: identifiers frozen once published
    p_ids_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> ($stable(id_vendor) && $stable(id_device)));
    // R9: no EEPROM traffic after loading
    p_cs_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !ee_cs);
    // R7: an all-ones first word ends the load with defaults
    p_absent_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !q.idx && (&word)) |=>
            (load_done && id_vendor == DATA_W'(VENDOR_DEF) && id_device == DATA_W'(DEVICE_DEF)));
endmodule

// File: tb/eeprom_id_loader_bench.sv
`timescale 1ns/100ps
module eeprom_id_loader_bench;
    localparam int HALF = 100;
    localparam logic [15:0] VDEF = 16'h1D7A;
    localparam logic [15:0] DDEF = 16'h0301;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] id_vendor, id_device;
    logic load_done;

    always #2.5 clk = ~clk;

    eeprom_id_loader #(.HALF_DIV(HALF)) u_eeprom_id_loader (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do), .id_vendor(id_vendor), .id_device(id_device), .load_done(load_done)
    );

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [0:63];
    bit          present = 1'b1;
    int          rise_cnt = 0;
    logic [8:0]  cmd_sh = '0;
    logic [5:0]  cur_addr = '0;
    int          reads = 0;
    realtime     t_rise1 = 0;
    logic        do_bit = 1'b1;
    int          low_cnt = 0;

    assign ee_do = present ? do_bit : 1'b1;

    always @(negedge clk) low_cnt = ee_cs ? 0 : low_cnt + 1;

    always @(posedge ee_cs or posedge ee_sk) begin
        if (!ee_sk) begin
            // new selection; R5 gap measured in low system cycles
            check(low_cnt >= 2*HALF, "R5", "select low cycles before read",
                  low_cnt, 2*HALF);
            rise_cnt = 0;
            cmd_sh   = '0;
        end else begin
            rise_cnt++;
            if (rise_cnt == 1) t_rise1 = $realtime;
            if (rise_cnt == 2)
                check(($realtime - t_rise1) == 2.0*HALF*5.0, "R4", "sk period ns",
                      longint'($realtime - t_rise1), 2*HALF*5);
            if (rise_cnt <= 9) cmd_sh = {cmd_sh[7:0], ee_di};
            if (rise_cnt == 9) begin
                check(cmd_sh[8:6] == 3'b110, "R2", "start+opcode bits", cmd_sh[8:6], 3'b110);
                check(cmd_sh[5:0] == 6'(reads), "R2", "word address", cmd_sh[5:0], reads);
                cur_addr = cmd_sh[5:0];
                reads++;
            end
        end
    end

    always @(negedge ee_sk) begin
        if (ee_cs && rise_cnt >= 9 && rise_cnt <= 24)
            do_bit = mem[cur_addr][24 - rise_cnt];
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] v;
        logic [15:0] d;
        int          nreads;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    int   popped = 0;

    initial begin
        forever begin
            @(posedge load_done);
            @(negedge clk);
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "done with nothing expected", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(id_vendor == e.v, e.tag, "vendor id", id_vendor, e.v);
                check(id_device == e.d, e.tag, "device id", id_device, e.d);
                check(reads == e.nreads, e.tag, "number of reads", reads, e.nreads);
            end
            popped++;
        end
    end

    // ---------------- driver ----------------
    task automatic run_case(input logic [15:0] w0, input logic [15:0] w1, input bit pres,
                            input logic [15:0] ev, input logic [15:0] ed, input int nr,
                            input string tag, input int abort_at);
        int p;
        int waited;
        exp_t e;
        mem[0]  = w0;
        mem[1]  = w1;
        present = pres;
        rst_n   = 1'b0;
        repeat (5) @(negedge clk);
        check(load_done == 1'b0, "R1", "done in reset", load_done, 0);
        check(ee_cs == 1'b0 && ee_sk == 1'b0, "R1", "cs/sk in reset", {ee_cs, ee_sk}, 0);
        check(id_vendor == VDEF && id_device == DDEF, "R1", "ids in reset",
              {id_vendor, id_device}, {VDEF, DDEF});
        reads = 0;
        rst_n = 1'b1;
        if (abort_at > 0) begin
            repeat (abort_at) @(negedge clk);
            check(load_done == 1'b0, "R10", "still loading at abort", load_done, 0);
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            reads = 0;
            rst_n = 1'b1;
        end
        e.v = ev; e.d = ed; e.nreads = nr; e.tag = tag;
        sb_q.push_back(e);
        p = popped;
        waited = 0;
        while (!ee_cs && waited < 3*HALF + 10) begin
            @(negedge clk);
            waited++;
        end
        check(ee_cs == 1'b1, "R1", "automatic start of read", ee_cs, 1);
        while (popped == p) @(negedge clk);
        // R9: nothing changes after done
        begin
            logic [15:0] v0, d0;
            int r0;
            bit ok = 1'b1;
            v0 = id_vendor; d0 = id_device; r0 = reads;
            repeat (6*HALF) begin
                @(negedge clk);
                if (!load_done || ee_cs || id_vendor != v0 || id_device != d0) ok = 1'b0;
            end
            check(ok && reads == r0, "R9", "held after done", reads, r0);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        run_case(16'h10EC, 16'h8139, 1'b1, 16'h10EC, 16'h8139, 2, "R6", 0);
        run_case(16'h10EC, 16'h8139, 1'b0, VDEF, DDEF, 1, "R7", 0);
        run_case(16'hFFFF, 16'h4242, 1'b1, VDEF, DDEF, 1, "R7", 0);
        run_case(16'h5A01, 16'hFFFF, 1'b1, 16'h5A01, 16'hFFFF, 2, "R8", 0);
        run_case(16'hA55A, 16'h0000, 1'b1, 16'hA55A, 16'h0000, 2, "R3", 0);
        run_case(16'h0001, 16'h8000, 1'b1, 16'h0001, 16'h8000, 2, "R3", 0);
        run_case(16'h1234, 16'h5678, 1'b1, 16'h1234, 16'h5678, 2, "R10", 7000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule